// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block sits behind the write path of a parallel flash array and turns a stream of bus write cycles into flash operations. Each write arrives as a one-cycle strobe that qualifies a 16-bit address and an 8-bit data value. Multi-cycle commands start with a fixed two-write unlock key. A third write picks the command: byte program, the extended six-write family (chip erase or boot-area lock), identification entry or identification exit.

When a command completes, the decoder raises a one-cycle pulse for it. For a program command it also presents the captured target address and data. It keeps a flag that shows whether identification mode is active. A write that does not fit the expected next step drops the sequence back to idle. A write of the exit code to any address leaves identification mode from any point in a sequence. While the array reports busy, writes are ignored.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset all command pulses are low, `idMode` is 0, `progAddr` and `progData` are 0, and the decoder is idle.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xA0@0x5555, followed by a fourth write at any address, raise `progPulse` for exactly the cycle after the fourth write is sampled. `progAddr`/`progData` then carry that write's address and data and hold them until the next program.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA and 0x10@0x5555 raise `eraseAllPulse` for the cycle after the last write.
- R4: The same six-write prefix ending in 0x40@0x5555 raises `bootLockPulse` for the cycle after the last write.
- R5: The writes 0xAA@0x5555, 0x55@0x2AAA and 0x90@0x5555 raise `idEnterPulse` and set `idMode` to 1 in the cycle after the third write.
- R6: The writes 0xAA@0x5555, 0x55@0x2AAA and 0xF0@0x5555 raise `idExitPulse` and clear `idMode` in the cycle after the third write.
- R7: A single write of data 0xF0 to any address has the same effect as R6, and returns the decoder to idle. This holds from idle and from any partly entered sequence, except after the program command has been armed.
- R8: A write whose address or data does not match the next expected step returns the decoder to idle and raises no pulse. The following write is decoded as the first write of a new sequence.
- R9: A strobe sampled while `busy` is 1 neither advances nor breaks a sequence and raises no pulse.
- R10: At most one command pulse is high in any cycle. Program, erase, boot lock and enter pulses never last two cycles in a row.
- R11: Once program is armed, the next accepted write is always program data, even if its data is 0xF0 or 0xAA. It raises `progPulse` and not `idExitPulse`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | One-cycle write qualifier |
| wrAddr | input | 16 | Write address |
| wrData | input | 8 | Write data |
| busy | input | 1 | Array busy; writes ignored while high |
| progPulse | output | 1 | Byte program command |
| progAddr | output | 16 | Captured program address |
| progData | output | 8 | Captured program data |
| eraseAllPulse | output | 1 | Chip erase command |
| bootLockPulse | output | 1 | Boot-area lock command |
| idEnterPulse | output | 1 | Identification entry command |
| idExitPulse | output | 1 | Identification exit command |
| idMode | output | 1 | Identification mode active |

## Verification
The hardest situation to reach from the ports is a sequence that is broken or escaped deep in the six-write path, or that is interrupted by a busy write partway through. Unprimed stimulus almost never gets five writes into a sequence. The directed stimulus builds each valid prefix to every depth and then applies a wrong address, a wrong data value, an exit byte or a busy write at that exact step. A biased random phase then draws addresses and data mostly from the key and command values, so long prefixes, back-to-back strobes and busy gaps occur often. Everything is compared against a history-based reference model on every clock.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;

  // unlock key data values and command codes
  localparam byte_t KEY_HI   = 8'hAA;
  localparam byte_t KEY_LO   = 8'h55;
  localparam byte_t OP_PROG  = 8'hA0;
  localparam byte_t OP_EXT   = 8'h80;
  localparam byte_t OP_IDIN  = 8'h90;
  localparam byte_t OP_IDOUT = 8'hF0;
  localparam byte_t OP_ERASE = 8'h10;
  localparam byte_t OP_BOOT  = 8'h40;

  typedef enum logic [2:0] {
    S_IDLE,   // nothing matched
    S_K1,     // first key seen
    S_K2,     // full key seen, waiting for opcode
    S_ARM,    // program armed, next write is target
    S_X3,     // extended opcode seen
    S_X4,     // second key first half seen
    S_X5      // second key complete, waiting for final opcode
  } seq_state_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic erase;
    logic boot;
    logic idIn;
    logic idOut;
  } strobe_t;

  // datapath -> control match flags
  typedef struct packed {
    logic keyHi;
    logic keyLo;
    logic isProg;
    logic isExt;
    logic isIdIn;
    logic isIdOut;
    logic isErase;
    logic isBoot;
  } match_t;

endpackage

// File: rtl/seq_match.sv
module seq_match
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic [ADDR_W-1:0] wrAddr,
  input  byte_t             wrData,
  output match_t            match
);

  logic atA;
  logic atB;

  always_comb begin
    atA           = (wrAddr == KEY_ADDR_A);
    atB           = (wrAddr == KEY_ADDR_B);
    match.keyHi   = atA && (wrData == KEY_HI);
    match.keyLo   = atB && (wrData == KEY_LO);
    match.isProg  = atA && (wrData == OP_PROG);
    match.isExt   = atA && (wrData == OP_EXT);
    match.isIdIn  = atA && (wrData == OP_IDIN);
    match.isErase = atA && (wrData == OP_ERASE);
    match.isBoot  = atA && (wrData == OP_BOOT);
    // exit code is honoured at any address
    match.isIdOut = (wrData == OP_IDOUT);
  end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import unlock_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStrobe,
  input  logic    busy,
  input  match_t  match,
  output strobe_t stb
);

  seq_state_e state;
  seq_state_e nextState;
  logic       accept;

  assign accept = wrStrobe && !busy;

  always_comb begin
    nextState = state;
    stb       = '0;
    if (accept) begin
      nextState = S_IDLE;
      unique case (state)
        S_IDLE: begin
          if (match.keyHi)        nextState = S_K1;
          else if (match.isIdOut) stb.idOut = 1'b1;
        end
        S_K1: begin
          if (match.keyLo)        nextState = S_K2;
          else if (match.isIdOut) stb.idOut = 1'b1;
        end
        S_K2: begin
          if (match.isProg)       nextState = S_ARM;
          else if (match.isExt)   nextState = S_X3;
          else if (match.isIdIn)  stb.idIn  = 1'b1;
          else if (match.isIdOut) stb.idOut = 1'b1;
        end
        S_ARM: begin
          stb.capture = 1'b1;
        end
        S_X3: begin
          if (match.keyHi)        nextState = S_X4;
          else if (match.isIdOut) stb.idOut = 1'b1;
        end
        S_X4: begin
          if (match.keyLo)        nextState = S_X5;
          else if (match.isIdOut) stb.idOut = 1'b1;
        end
        S_X5: begin
          if (match.isErase)      stb.erase = 1'b1;
          else if (match.isBoot)  stb.boot  = 1'b1;
          else if (match.isIdOut) stb.idOut = 1'b1;
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // busy writes leave the sequence untouched
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(state));

  // no strobe, no movement
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |=> $stable(state));

  // armed program consumes the next accepted write and returns to idle
  assert_arm_consume_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ARM && wrStrobe && !busy) |=> (state == S_IDLE));

  // armed program never yields an exit
  assert_arm_no_exit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ARM) |-> !stb.idOut);

endmodule

// File: rtl/seq_dp.sv
module seq_dp
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  byte_t             wrData,
  input  strobe_t           stb,
  output logic              progPulse,
  output logic [ADDR_W-1:0] progAddr,
  output byte_t             progData,
  output logic              eraseAllPulse,
  output logic              bootLockPulse,
  output logic              idEnterPulse,
  output logic              idExitPulse,
  output logic              idMode
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progPulse     <= 1'b0;
      eraseAllPulse <= 1'b0;
      bootLockPulse <= 1'b0;
      idEnterPulse  <= 1'b0;
      idExitPulse   <= 1'b0;
    end else begin
      progPulse     <= stb.capture;
      eraseAllPulse <= stb.erase;
      bootLockPulse <= stb.boot;
      idEnterPulse  <= stb.idIn;
      idExitPulse   <= stb.idOut;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progAddr <= '0;
      progData <= '0;
    end else if (stb.capture) begin
      progAddr <= wrAddr;
      progData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          idMode <= 1'b0;
    else if (stb.idIn)  idMode <= 1'b1;
    else if (stb.idOut) idMode <= 1'b0;
  end

  assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({progPulse, eraseAllPulse, bootLockPulse, idEnterPulse, idExitPulse}));

  assert_prog_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    progPulse |=> !progPulse);

  assert_erase_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    eraseAllPulse |=> !eraseAllPulse);

  assert_enter_sets_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    idEnterPulse |-> idMode);

  assert_exit_clears_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    idExitPulse |-> !idMode);

  assert_prog_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !progPulse |=> (progPulse || $stable(progAddr)));

endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
  import unlock_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
  parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  output logic              progPulse,
  output logic [ADDR_W-1:0] progAddr,
  output logic [7:0]        progData,
  output logic              eraseAllPulse,
  output logic              bootLockPulse,
  output logic              idEnterPulse,
  output logic              idExitPulse,
  output logic              idMode
);

  match_t  match;
  strobe_t stb;

  seq_match #(
    .ADDR_W    (ADDR_W),
    .KEY_ADDR_A(KEY_ADDR_A),
    .KEY_ADDR_B(KEY_ADDR_B)
  ) u_match (
    .wrAddr(wrAddr),
    .wrData(wrData),
    .match (match)
  );

  seq_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrStrobe(wrStrobe),
    .busy    (busy),
    .match   (match),
    .stb     (stb)
  );

  seq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .stb          (stb),
    .progPulse    (progPulse),
    .progAddr     (progAddr),
    .progData     (progData),
    .eraseAllPulse(eraseAllPulse),
    .bootLockPulse(bootLockPulse),
    .idEnterPulse (idEnterPulse),
    .idExitPulse  (idExitPulse),
    .idMode       (idMode)
  );

endmodule

// File: tb/unlock_seq_decoder_bench.sv
`timescale 1ns/1ps
module unlock_seq_decoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStrobe = 1'b0;
  logic [15:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic        busy = 1'b0;
  logic        progPulse, eraseAllPulse, bootLockPulse, idEnterPulse, idExitPulse, idMode;
  logic [15:0] progAddr;
  logic [7:0]  progData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  unlock_seq_decoder u_unlock_seq_decoder (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .progPulse(progPulse), .progAddr(progAddr), .progData(progData),
    .eraseAllPulse(eraseAllPulse), .bootLockPulse(bootLockPulse),
    .idEnterPulse(idEnterPulse), .idExitPulse(idExitPulse), .idMode(idMode)
  );

  // ---------------- reference model: history of accepted writes ----------------
  typedef struct { logic [15:0] a; logic [7:0] d; } wr_t;
  wr_t hist[$];
  logic        eProg = 0, eErase = 0, eBoot = 0, eIn = 0, eOut = 0, eMode = 0;
  logic [15:0] eAddr = 0;
  logic [7:0]  eData = 0;

  function automatic bit keyStep(int pos, wr_t w);
    case (pos)
      0, 3: return (w.a == 16'h5555 && w.d == 8'hAA);
      1, 4: return (w.a == 16'h2AAA && w.d == 8'h55);
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    eProg = 0; eErase = 0; eBoot = 0; eIn = 0; eOut = 0;
    if (!rstN) begin
      hist.delete(); eMode = 0; eAddr = 0; eData = 0;
    end else if (wrStrobe && !busy) begin
      wr_t w;
      int pos;
      w.a = wrAddr; w.d = wrData;
      hist.push_back(w);
      pos = hist.size() - 1;
      if (pos == 3 && hist[2].d == 8'hA0) begin
        eProg = 1; eAddr = w.a; eData = w.d; hist.delete();
      end else if (w.d == 8'hF0) begin
        eOut = 1; eMode = 0; hist.delete();
      end else if (pos == 2) begin
        if (w.a == 16'h5555 && w.d == 8'h90) begin
          eIn = 1; eMode = 1; hist.delete();
        end else if (!(w.a == 16'h5555 && (w.d == 8'hA0 || w.d == 8'h80))) hist.delete();
      end else if (pos == 5) begin
        if (w.a == 16'h5555 && w.d == 8'h10) eErase = 1;
        else if (w.a == 16'h5555 && w.d == 8'h40) eBoot = 1;
        hist.delete();
      end else if (!keyStep(pos, w)) hist.delete();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) if (!done) begin
    chk("R2 progPulse", progPulse, eProg);
    chk("R2 progAddr", progAddr, eAddr);
    chk("R2 progData", progData, eData);
    chk("R3 eraseAllPulse", eraseAllPulse, eErase);
    chk("R4 bootLockPulse", bootLockPulse, eBoot);
    chk("R5 idEnterPulse", idEnterPulse, eIn);
    chk("R6/R7 idExitPulse", idExitPulse, eOut);
    chk("R5/R6 idMode", idMode, eMode);
    chk("R10 pulse count", $countones({progPulse, eraseAllPulse, bootLockPulse,
                                      idEnterPulse, idExitPulse}) <= 1, 1);
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [15:0] a, logic [7:0] d, logic b = 1'b0);
    @(negedge clk);
    wrStrobe = 1'b1; wrAddr = a; wrData = d; busy = b;
    @(negedge clk);
    wrStrobe = 1'b0; busy = 1'b0;
  endtask

  task automatic key();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
  endtask

  task automatic extPrefix();
    key(); wr(16'h5555, 8'h80); key();
  endtask

  task automatic quiet(string tag);
    chk({tag, " no pulse"}, {progPulse, eraseAllPulse, bootLockPulse, idEnterPulse, idExitPulse}, 0);
  endtask

  // build prefix of given depth along the extended path
  task automatic prefix(int depth);
    if (depth > 0) wr(16'h5555, 8'hAA);
    if (depth > 1) wr(16'h2AAA, 8'h55);
    if (depth > 2) wr(16'h5555, 8'h80);
    if (depth > 3) wr(16'h5555, 8'hAA);
    if (depth > 4) wr(16'h2AAA, 8'h55);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 idMode", idMode, 0);
    chk("R1 progAddr", progAddr, 0);
    quiet("R1");
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: program
    key(); wr(16'h5555, 8'hA0); wr(16'h1234, 8'h5A);
    chk("R2 pulse", progPulse, 1);
    chk("R2 addr", progAddr, 16'h1234);
    chk("R2 data", progData, 8'h5A);
    @(negedge clk);
    chk("R2 hold addr", progAddr, 16'h1234);

    // R11: armed write with exit code / key data is program data
    key(); wr(16'h5555, 8'hA0); wr(16'hBEEF, 8'hF0);
    chk("R11 prog", progPulse, 1);
    chk("R11 no exit", idExitPulse, 0);
    key(); wr(16'h5555, 8'hA0); wr(16'h5555, 8'hAA);
    chk("R11 prog key data", progPulse, 1);

    // R3 / R4
    extPrefix(); wr(16'h5555, 8'h10);
    chk("R3 erase", eraseAllPulse, 1);
    extPrefix(); wr(16'h5555, 8'h40);
    chk("R4 boot", bootLockPulse, 1);

    // R5 / R6
    key(); wr(16'h5555, 8'h90);
    chk("R5 enter", idEnterPulse, 1);
    chk("R5 mode", idMode, 1);
    key(); wr(16'h5555, 8'hF0);
    chk("R6 exit", idExitPulse, 1);
    chk("R6 mode", idMode, 0);

    // R7: single exit from idle and from every partial depth
    key(); wr(16'h5555, 8'h90);
    wr(16'h0042, 8'hF0);
    chk("R7 idle exit", idExitPulse, 1);
    chk("R7 idle mode", idMode, 0);
    for (int dep = 1; dep <= 5; dep++) begin
      key(); wr(16'h5555, 8'h90);
      prefix(dep); wr(16'h7000 + 16'(dep), 8'hF0);
      chk("R7 partial exit", idExitPulse, 1);
      chk("R7 partial mode", idMode, 0);
      key(); wr(16'h5555, 8'hA0); wr(16'h0100, 8'h11);
      chk("R7 back to idle", progPulse, 1);
    end

    // R8: wrong address and wrong data at every step
    for (int dep = 0; dep <= 5; dep++) begin
      prefix(dep); wr(16'h3333, (dep == 1 || dep == 4) ? 8'h55 : 8'hAA);
      quiet("R8 bad addr");
      prefix(dep); wr((dep == 1 || dep == 4) ? 16'h2AAA : 16'h5555, 8'h33);
      quiet("R8 bad data");
      key(); wr(16'h5555, 8'hA0); wr(16'h0200, 8'h22);
      chk("R8 restart", progPulse, 1);
    end
    // abort then final opcode of a dead sequence: no erase
    prefix(4); wr(16'h1111, 8'h55); wr(16'h5555, 8'h10);
    chk("R8 no erase", eraseAllPulse, 0);

    // R9: busy writes ignored
    key(); wr(16'h5555, 8'hA0, 1'b1); wr(16'h0300, 8'h33, 1'b1);
    chk("R9 busy no prog", progPulse, 0);
    wr(16'h5555, 8'hA0); wr(16'h0300, 8'h33);
    chk("R9 resumed prog", progPulse, 1);
    key(); wr(16'h0000, 8'hF0, 1'b1); wr(16'h5555, 8'h90);
    chk("R9 busy exit ignored", idEnterPulse, 1);
    wr(16'h0000, 8'hF0);

    // back-to-back strobes: R10
    @(negedge clk); wrStrobe = 1; wrAddr = 16'h0; wrData = 8'hF0;
    @(negedge clk); wrData = 8'hF0;
    @(negedge clk); wrStrobe = 0;
    chk("R10 exit can repeat", idExitPulse, 1);

    // biased random phase
    for (int i = 0; i < 20000; i++) begin
      int r;
      @(negedge clk);
      wrStrobe = ($urandom_range(0, 9) < 7);
      busy = ($urandom_range(0, 9) < 1);
      r = $urandom_range(0, 9);
      wrAddr = (r < 5) ? 16'h5555 : (r < 8) ? 16'h2AAA : 16'($urandom);
      r = $urandom_range(0, 11);
      case (r)
        0, 1, 2: wrData = 8'hAA;
        3, 4:    wrData = 8'h55;
        5:       wrData = 8'hA0;
        6:       wrData = 8'h80;
        7:       wrData = 8'h90;
        8:       wrData = 8'hF0;
        9:       wrData = 8'h10;
        10:      wrData = 8'h40;
        default: wrData = 8'($urandom);
      endcase
    end
    @(negedge clk); wrStrobe = 0; busy = 0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule